// File: doc/BRIEF.md
# Single-MAC Programmable FIR Filter

This block is a direct-form FIR filter that forms each output sample by reusing one multiply-accumulate unit over all taps, one product per clock. Accepted input samples go into a circular history store. The filter weights sit in a second store that a host can rewrite at any time through a simple write port, so the response can change at run time without rebuilding the design.

When a sample arrives while the engine is idle, the block stores it, captures the requested tap count and starts a sequence. A controller walks both stores, newest sample against weight 0 and older samples against higher weight indices. A 32-bit accumulator sums the products. The result is rounded and saturated to a 16-bit word and is flagged by a one-cycle valid pulse. While a sequence runs, a busy flag is high and new samples are dropped.

Top module: `fir_smac`

## Requirements
- R1: After reset, `y_data` is 0 and `y_vld` and `busy` are low. Reset clears every weight and every stored sample to zero, so outputs computed before any weight is written are 0.
- R2: A sample is accepted when `smp_vld` is high and `busy` is low at a clock edge. `busy` is high from the next cycle until the result is delivered. A `smp_vld` pulse while `busy` is high is ignored: it neither starts a computation nor enters the history.
- R3: With N taps, the output is the sum over k = 0..N-1 of w[k]·x[n-k], where x[n] is the newest accepted sample and w[k] is the weight written at `coef_addr` = k. All words are signed two's complement, and the sum wraps modulo 2^32.
- R4: Weights are Q15. The 32-bit sum has 2^14 added and is then shifted right arithmetically by 15, which rounds halves toward plus infinity (-1.5 becomes -1, 1.5 becomes 2).
- R5: A rounded value above 32767 gives 32767, and a value below -32768 gives -32768.
- R6: `y_vld` is a single-cycle pulse that rises at the (N+2)-th clock edge after the accepting edge. `busy` falls at that same edge, and `y_data` changes only at an edge that raises `y_vld`.
- R7: The tap count `taps` is captured at acceptance. A value of 0 is treated as 1, and a value above 64 is treated as 64.
- R8: A weight write (`coef_we` high, with `coef_addr` and `coef_data`) takes effect for every computation that starts afterwards.
- R9: The history is a circular store of 64 samples. With N = 64 the oldest sample used is the one accepted 63 samples before the newest, and older samples never contribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Input sample valid |
| smp_data | input | 16 | Input sample, signed |
| taps | input | 7 | Tap count for the next computation |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | 6 | Weight index to write |
| coef_data | input | 16 | Weight value, signed Q15 |
| y_data | output | 16 | Rounded, saturated output sample |
| y_vld | output | 1 | Output valid pulse |
| busy | output | 1 | Accumulation in progress |

## Verification
The bench builds the block with its defaults: 64-deep stores, 16-bit words, a 32-bit accumulator and a rounding shift of 15. These values allow a full 64-tap sweep with more than 64 samples, which exercises the wrap of the circular history. They also allow tap requests of 0 and 100, which exercise the clamping. With Q15 weights near full scale, two large products push the rounded result past the 16-bit range in both directions, which tests the saturation. A half-weight single tap gives exact ties, which tests the rounding direction.

// File: rtl/fir_smac_pkg.sv
package fir_smac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2,
      ST_ROUND = 2'd3
   } seq_state_e;
endpackage

// File: rtl/fir_smac_ram.sv
module fir_smac_ram #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 16,
   parameter bit CLEAR = 1'b1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   // registered read port: acts as the operand register in front of the multiplier
   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/fir_smac_ctrl.sv
module fir_smac_ctrl
   import fir_smac_pkg::*;
#(
   parameter int MAX_TAPS = 64,
   localparam int AW      = $clog2(MAX_TAPS),
   localparam int TW      = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [TW-1:0] taps_i,
   output logic          busy,
   output logic          x_we,
   output logic [AW-1:0] x_waddr,
   output logic          rd_en,
   output logic [AW-1:0] x_raddr,
   output logic [AW-1:0] c_raddr,
   output logic          tap_first,
   output logic          tap_last
);
   seq_state_e    state;
   logic [AW-1:0] idx;
   logic [AW-1:0] last_idx;
   logic [AW-1:0] wptr;
   logic [TW-1:0] taps_cl;
   logic          accept;

   always_comb begin
      if (taps_i == '0)                   taps_cl = TW'(1);
      else if (taps_i > TW'(MAX_TAPS))    taps_cl = TW'(MAX_TAPS);
      else                                taps_cl = taps_i;
   end

   assign accept  = smp_vld && (state == ST_IDLE);
   assign x_we    = accept;
   assign x_waddr = wptr + AW'(1);
   assign busy    = (state != ST_IDLE);

   assign rd_en     = (state == ST_RUN);
   assign x_raddr   = wptr - idx;
   assign c_raddr   = idx;
   assign tap_first = rd_en && (idx == '0);
   assign tap_last  = rd_en && (idx == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         last_idx <= '0;
         wptr     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               wptr     <= wptr + AW'(1);
               last_idx <= AW'(taps_cl - TW'(1));
               idx      <= '0;
               state    <= ST_RUN;
            end
            ST_RUN: begin
               if (idx == last_idx) state <= ST_FLUSH;
               else                 idx   <= idx + AW'(1);
            end
            ST_FLUSH: state <= ST_ROUND;
            ST_ROUND: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fir_smac_mac.sv
module fir_smac_mac #(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int ACC_W = 32,
   parameter int SHIFT = 15,
   localparam int PW   = DW + CW,
   localparam int EW   = ACC_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          tap_first,
   input  logic          tap_last,
   input  logic [DW-1:0] x_q,
   input  logic [CW-1:0] c_q,
   output logic [DW-1:0] y_data,
   output logic          y_vld
);
   localparam logic signed [EW-1:0] YMAX = (EW'(1) <<< (DW-1)) - EW'(1);
   localparam logic signed [EW-1:0] YMIN = -(EW'(1) <<< (DW-1));

   logic                    s1_v, s1_first, s1_last, s2_last;
   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] prod_ext;
   logic signed [ACC_W-1:0] acc;
   logic signed [EW-1:0]    shifted;
   logic [DW-1:0]           y_next;

   assign prod     = $signed(x_q) * $signed(c_q);
   assign prod_ext = ACC_W'(prod);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s2_last <= 1'b0;
         acc  <= '0;
      end else begin
         s1_v     <= rd_en;
         s1_first <= tap_first;
         s1_last  <= tap_last;
         s2_last  <= s1_v && s1_last;
         if (s1_v) acc <= s1_first ? prod_ext : acc + prod_ext;
      end
   end

   generate
      if (SHIFT > 0) begin : g_round
         localparam logic signed [EW-1:0] HALF = EW'(1) <<< (SHIFT-1);
         logic signed [EW-1:0] biased;
         assign biased  = EW'(acc) + HALF;
         assign shifted = biased >>> SHIFT;
      end else begin : g_noround
         assign shifted = EW'(acc);
      end
   endgenerate

   always_comb begin
      if (shifted > YMAX)      y_next = {1'b0, {(DW-1){1'b1}}};
      else if (shifted < YMIN) y_next = {1'b1, {(DW-1){1'b0}}};
      else                     y_next = shifted[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_data <= '0;
         y_vld  <= 1'b0;
      end else begin
         y_vld <= s2_last;
         if (s2_last) y_data <= y_next;
      end
   end
endmodule

// File: rtl/fir_smac.sv
module fir_smac #(
   parameter int MAX_TAPS = 64,
   parameter int DW       = 16,
   parameter int CW       = 16,
   parameter int ACC_W    = 32,
   parameter int SHIFT    = 15,
   localparam int AW      = $clog2(MAX_TAPS),
   localparam int TW      = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp_data,
   input  logic [TW-1:0] taps,
   input  logic          coef_we,
   input  logic [AW-1:0] coef_addr,
   input  logic [CW-1:0] coef_data,
   output logic [DW-1:0] y_data,
   output logic          y_vld,
   output logic          busy
);
   generate
      if ((1 << AW) != MAX_TAPS || MAX_TAPS < 2 || MAX_TAPS > 64)
         $error("MAX_TAPS must be a power of two between 2 and 64");
      if (ACC_W < DW + CW)
         $error("ACC_W must hold a full product");
      if (SHIFT >= ACC_W || ACC_W + 1 - SHIFT <= DW)
         $error("SHIFT leaves no room for the output field");
   endgenerate

   logic          x_we, rd_en, tap_first, tap_last;
   logic [AW-1:0] x_waddr, x_raddr, c_raddr;
   logic [DW-1:0] x_q;
   logic [CW-1:0] c_q;

   fir_smac_ctrl #(.MAX_TAPS(MAX_TAPS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .taps_i(taps),
      .busy(busy), .x_we(x_we), .x_waddr(x_waddr), .rd_en(rd_en),
      .x_raddr(x_raddr), .c_raddr(c_raddr),
      .tap_first(tap_first), .tap_last(tap_last)
   );

   fir_smac_ram #(.DEPTH(MAX_TAPS), .WIDTH(DW), .CLEAR(1'b1)) u_xram (
      .clk(clk), .rst_n(rst_n), .we(x_we), .waddr(x_waddr), .wdata(smp_data),
      .re(rd_en), .raddr(x_raddr), .rdata(x_q)
   );

   fir_smac_ram #(.DEPTH(MAX_TAPS), .WIDTH(CW), .CLEAR(1'b1)) u_cram (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
      .re(rd_en), .raddr(c_raddr), .rdata(c_q)
   );

   fir_smac_mac #(.DW(DW), .CW(CW), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_mac (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .tap_first(tap_first),
      .tap_last(tap_last), .x_q(x_q), .c_q(c_q), .y_data(y_data), .y_vld(y_vld)
   );
endmodule

// File: rtl/fir_smac_chk.sv
module fir_smac_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_vld,
   input logic [DW-1:0] y_data,
   input logic          y_vld,
   input logic          busy
);
   a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !busy) |=> busy);

   a_r2_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
      y_vld |-> !busy);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      y_vld |=> !y_vld);

   a_r6_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> y_vld);

   a_r6_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !y_vld |-> $stable(y_data));
endmodule

bind fir_smac fir_smac_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
   .y_data(y_data), .y_vld(y_vld), .busy(busy)
);

// File: tb/fir_smac_test.sv
module fir_smac_test;
   localparam int DW = 16;
   localparam int AW = 6;
   localparam int TW = 7;
   localparam int NV = 6;
   // {sample, expected output} with weights w0=0.5, w1=0.25, w2=-0.5, three taps
   localparam logic [31:0] VEC [NV] = '{
      {16'(1000),  16'(500)},
      {16'(2000),  16'(1250)},
      {16'(-4000), 16'(-2000)},
      {16'(3),     16'(-1998)},
      {16'(1),     16'(2001)},
      {16'(-1),    16'(-2)}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic [TW-1:0] taps = '0;
   logic          coef_we = 1'b0;
   logic [AW-1:0] coef_addr = '0;
   logic [DW-1:0] coef_data = '0;
   logic [DW-1:0] y_data;
   logic          y_vld;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;
   int hist [64];
   int coef [64];
   int hp = 0;
   int cyc = 0;
   bit done = 1'b0;

   fir_smac uut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .taps(taps), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_data(coef_data), .y_data(y_data), .y_vld(y_vld), .busy(busy)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int n);
      longint sum = 0;
      int nn = (n == 0) ? 1 : ((n > 64) ? 64 : n);
      int acc;
      longint q;
      for (int k = 0; k < nn; k++) sum += longint'(hist[(hp - k + 64) % 64]) * longint'(coef[k]);
      acc = int'(sum);
      q = (longint'(acc) + 16384) >>> 15;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return int'(q);
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 64; i++) begin hist[i] = 0; coef[i] = 0; end
      hp = 0;
   endtask

   task automatic wcoef(input int a, input int v);
      @(negedge clk); coef_we = 1'b1; coef_addr = AW'(a); coef_data = DW'(v);
      @(negedge clk); coef_we = 1'b0;
      coef[a] = v;
   endtask

   task automatic push(input int s, input int n, output int y, output int lat);
      @(negedge clk); smp_vld = 1'b1; smp_data = DW'(s); taps = TW'(n);
      @(negedge clk); smp_vld = 1'b0;
      hp = (hp + 1) % 64; hist[hp] = s;
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
      lat = 0;
      while (!y_vld && lat < 300) begin @(negedge clk); lat++; end
      y = int'($signed(y_data));
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      int y, lat, e;
      do_reset();
      @(negedge clk);
      // R1: reset state at the ports
      check(y_data == '0, "R1 y_data after reset", int'(y_data), 0);
      check(y_vld == 1'b0, "R1 y_vld after reset", int'(y_vld), 0);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      // R1: weights are zero after reset
      push(1234, 64, y, lat);
      check(y == 0, "R1 zero weights give zero", y, 0);

      // table walk after a fresh reset: R1 clears history, R3 sum, R4 rounding
      do_reset();
      wcoef(0, 16384); wcoef(1, 8192); wcoef(2, -16384);
      for (int i = 0; i < NV; i++) begin
         push(int'($signed(VEC[i][31:16])), 3, y, lat);
         e = int'($signed(VEC[i][15:0]));
         check(y == e, "R3 table output", y, e);
         check(lat == 5, "R6 latency three taps", lat, 5);
      end

      // R6: y_vld lasts one cycle, busy already low
      check(busy == 1'b0, "R6 busy low with result", int'(busy), 0);
      @(negedge clk);
      check(y_vld == 1'b0, "R6 single-cycle valid", int'(y_vld), 0);

      // R2: sample during busy ignored
      @(negedge clk); smp_vld = 1'b1; smp_data = DW'(777); taps = TW'(3);
      @(negedge clk); smp_vld = 1'b0;
      hp = (hp + 1) % 64; hist[hp] = 777;
      @(negedge clk); smp_vld = 1'b1; smp_data = DW'(30000);
      @(negedge clk); smp_vld = 1'b0;
      lat = 0;
      while (!y_vld && lat < 300) begin @(negedge clk); lat++; end
      e = model(3);
      check(int'($signed(y_data)) == e, "R2 busy sample ignored", int'($signed(y_data)), e);
      push(5, 3, y, lat);
      e = model(3);
      check(y == e, "R2 ignored sample not in history", y, e);

      // R4: tie rounding on negative and positive halves
      do_reset();
      wcoef(0, 16384);
      push(-3, 1, y, lat);
      check(y == -1, "R4 -1.5 rounds to -1", y, -1);
      check(lat == 3, "R6 latency one tap", lat, 3);
      push(3, 1, y, lat);
      check(y == 2, "R4 1.5 rounds to 2", y, 2);

      // R5: saturation both ways
      wcoef(0, 32767); wcoef(1, 32767);
      push(32767, 2, y, lat);
      push(32767, 2, y, lat);
      check(y == 32767, "R5 positive saturation", y, 32767);
      push(-32768, 2, y, lat);
      push(-32768, 2, y, lat);
      check(y == -32768, "R5 negative saturation", y, -32768);

      // R8: rewrite weights at run time
      wcoef(0, -8192); wcoef(1, 0);
      push(400, 2, y, lat);
      e = model(2);
      check(y == e && e == -100, "R8 new weight used", y, -100);

      // R7: tap count clamp
      for (int k = 0; k < 64; k++) wcoef(k, 1000 + 37 * k - 25 * (k % 5));
      push(2500, 0, y, lat);
      e = model(0);
      check(y == e, "R7 zero taps acts as one", y, e);
      check(lat == 3, "R7 zero taps latency", lat, 3);
      push(-1800, 100, y, lat);
      e = model(100);
      check(y == e, "R7 oversize taps acts as 64", y, e);
      check(lat == 66, "R7 oversize taps latency", lat, 66);

      // R9: circular history over more than 64 samples, full 64 taps
      for (int i = 0; i < 70; i++) begin
         push((i * 911) % 4001 - 2000, 64, y, lat);
         e = model(64);
         if (i >= 64 || i % 16 == 0)
            check(y == e, "R9 circular history", y, e);
      end
      check(lat == 66, "R6 latency 64 taps", lat, 66);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule